// File: doc/BRIEF.md
# Multi-Format Page Table Walker

This block turns a virtual address into a physical address for debug and probe paths. It reads page-table entries through a single 64-bit read port with valid/ready request and valid-only response signalling. It returns either the translated address with the size of the page that mapped it, or a fault. Four table formats are handled by one state machine: paging off, legacy 32-bit two-level tables with optional 4 MB pages, three-level PAE tables, and four-level long-mode tables with 2 MB and 1 GB large pages.

The caller presents a virtual address together with the paging configuration: paging on, PAE on, long mode on, large-page enable for 32-bit tables, A20 gate enable and table root. The configuration is captured when the request is accepted. The walker has at most one memory read outstanding. It accepts no new request until the result of the current one has been delivered.

Top module: `pt_walker`

## Requirements
- R1: With cfg_paging_i low, the result is req_va_i with bit 20 forced to 0 when cfg_a20_en_i is low (otherwise unchanged), page size code 0 (4 KB), no fault, and no memory read is issued.
- R2: Legacy mode (paging on, PAE off) reads the directory entry at (root with bits 11:0 cleared) + VA[31:22]*4 and the table entry at (directory entry with bits 11:0 cleared) + VA[21:12]*4. Both are narrow reads (mem_req_wide_o = 0), and only bits 31:0 of the returned data are used.
- R3: In legacy mode, a directory entry with bit 7 set while cfg_pse_i is high ends the walk as a 4 MB page (size code 2), and entry bits 20:13 become physical bits 39:32. With cfg_pse_i low, the same entry points to a table.
- R4: PAE mode (PAE on, long off) first reads at (root with bits 4:0 cleared) + VA[31:30]*8. It then reads a directory at index VA[29:21] and a table at index VA[20:12], each index times 8. All reads are wide.
- R5: Long mode (PAE and long on) walks four levels with 9-bit indices VA[47:39], VA[38:30], VA[29:21] and VA[20:12], each times 8. The base of each level is the root or the previous entry, masked to bits PA_W-1:12.
- R6: In long mode, a level-3 entry with bit 7 set ends the walk as a 1 GB page (size code 3). In PAE or long mode, a directory entry with bit 7 set ends it as a 2 MB page (size code 1).
- R7: In long mode, a VA whose bits 63:47 are not all equal faults at once, without any memory read.
- R8: Any entry read with bit 0 clear ends the walk with res_fault_o = 1, res_pa_o = 0 and res_size_o = 0.
- R9: With cfg_a20_en_i low, every entry address issued has bit 20 cleared. In legacy mode, bit 20 of the final frame is cleared as well.
- R10: The result is the leaf frame, restricted to bits PA_W-1 down to the page size, ORed with the VA bits below the page size. Entry flag bits and bits at PA_W and above do not reach the result.
- R11: One read is outstanding at most, and a request address is held stable until accepted. req_ready_o is low from the cycle after acceptance until after the result. res_valid_o lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted this cycle |
| req_va_i | input | 64 | Virtual address |
| cfg_paging_i | input | 1 | Paging enabled |
| cfg_pae_i | input | 1 | 64-bit entry formats |
| cfg_long_i | input | 1 | Four-level format (with cfg_pae_i) |
| cfg_pse_i | input | 1 | Allow 4 MB pages in legacy mode |
| cfg_a20_en_i | input | 1 | A20 gate open (bit 20 passes) |
| cfg_root_i | input | 64 | Table root |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_addr_o | output | 64 | Entry byte address |
| mem_req_wide_o | output | 1 | 1: 64-bit entry, 0: 32-bit entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Read data |
| res_valid_o | output | 1 | Result valid, one cycle |
| res_fault_o | output | 1 | Translation failed |
| res_pa_o | output | 64 | Physical address |
| res_size_o | output | 2 | Page size: 0 4 KB, 1 2 MB, 2 4 MB, 3 1 GB |

## Verification
The assertions assume that the memory side returns exactly one response per accepted read, and never a response with no read pending. They also assume that the configuration inputs are sampled only at acceptance, so the A20 check latches the gate setting at that edge. The bench's memory model answers only after a handshake, with a fixed latency. It withholds ready on every other read to exercise holding the request. It changes the configuration only while the walker is idle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned VA_W     = 64;
  localparam int unsigned PG_SHIFT = 12;
  localparam int unsigned IDX_W    = 9;
  localparam int unsigned N_LVL    = 4;
  localparam int unsigned BIT_P    = 0;
  localparam int unsigned BIT_PS   = 7;
  localparam int unsigned A20_BIT  = 20;

  typedef enum logic [1:0] {MODE_FLAT, MODE_LEG32, MODE_PAE3, MODE_LONG4} walk_mode_e;
  typedef enum logic [1:0] {LVL_PT = 2'd0, LVL_PD = 2'd1, LVL_PDPT = 2'd2, LVL_PML4 = 2'd3} walk_lvl_e;
  typedef enum logic [1:0] {PG_4K = 2'd0, PG_2M = 2'd1, PG_4M = 2'd2, PG_1G = 2'd3} pg_size_e;

  function automatic int unsigned size_shift(pg_size_e s);
    case (s)
      PG_2M:   return 21;
      PG_4M:   return 22;
      PG_1G:   return 30;
      default: return 12;
    endcase
  endfunction

  function automatic logic [VA_W-1:0] a20_mask(logic en);
    return en ? '1 : ~(64'd1 << A20_BIT);
  endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  walk_mode_e        mode_i,
  input  walk_lvl_e         lvl_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [VA_W-1:0]   base_i,
  input  logic              a20_en_i,
  output logic [VA_W-1:0]   addr_o,
  output logic              wide_o
);
  logic [N_LVL-1:0][VA_W-1:0] wide_off;
  logic [VA_W-1:0]            off;

  for (genvar g = 0; g < N_LVL; g++) begin : g_slice
    assign wide_off[g] = VA_W'(va_i[PG_SHIFT + IDX_W*g +: IDX_W]) << 3;
  end

  always_comb begin
    case (mode_i)
      MODE_LEG32: off = (lvl_i == LVL_PD) ? VA_W'(va_i[31:22]) << 2
                                          : VA_W'(va_i[21:12]) << 2;
      MODE_PAE3:  off = (lvl_i == LVL_PDPT) ? VA_W'(va_i[31:30]) << 3
                                            : wide_off[lvl_i];
      default:    off = wide_off[lvl_i];
    endcase
  end

  assign addr_o = (base_i + off) & a20_mask(a20_en_i);
  assign wide_o = (mode_i != MODE_LEG32);

  logic unused_va;
  assign unused_va = ^va_i[VA_W-1:48];
endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec
  import ptw_pkg::*;
#(
  parameter int unsigned PA_W = 52
) (
  input  walk_mode_e       mode_i,
  input  walk_lvl_e        lvl_i,
  input  logic [VA_W-1:0]  data_i,
  input  logic             pse_en_i,
  output logic             present_o,
  output logic             leaf_o,
  output pg_size_e         size_o,
  output logic [VA_W-1:0]  next_base_o,
  output logic [VA_W-1:0]  entry_o
);
  localparam logic [VA_W-1:0] FRAME_MASK = ((64'd1 << PA_W) - 64'd1) & ~64'hFFF;

  logic [VA_W-1:0] ent;
  logic            ps;

  assign ent       = (mode_i == MODE_LEG32) ? {32'h0, data_i[31:0]} : data_i;
  assign present_o = ent[BIT_P];
  assign ps        = ent[BIT_PS];
  assign entry_o   = ent;

  always_comb begin
    leaf_o = 1'b0;
    size_o = PG_4K;
    case (lvl_i)
      LVL_PT: leaf_o = 1'b1;
      LVL_PD: begin
        if (mode_i == MODE_LEG32) begin
          leaf_o = ps & pse_en_i;
          size_o = PG_4M;
        end else begin
          leaf_o = ps;
          size_o = PG_2M;
        end
      end
      LVL_PDPT: begin
        leaf_o = ps & (mode_i == MODE_LONG4);
        size_o = PG_1G;
      end
      default: ;
    endcase
  end

  assign next_base_o = (mode_i == MODE_LEG32) ? {ent[VA_W-1:12], 12'h000}
                                              : (ent & FRAME_MASK);
endmodule

// File: rtl/ptw_result_fmt.sv
module ptw_result_fmt
  import ptw_pkg::*;
#(
  parameter int unsigned PA_W = 52
) (
  input  logic             flat_i,
  input  walk_mode_e       mode_i,
  input  pg_size_e         size_i,
  input  logic [VA_W-1:0]  entry_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic             a20_en_i,
  output logic [VA_W-1:0]  pa_o
);
  localparam logic [VA_W-1:0] PA_FIELD = (64'd1 << PA_W) - 64'd1;

  logic [N_LVL-1:0][VA_W-1:0] low_mask;
  logic [VA_W-1:0]            e;
  logic [VA_W-1:0]            lm;

  for (genvar s = 0; s < N_LVL; s++) begin : g_mask
    assign low_mask[s] = (64'd1 << size_shift(pg_size_e'(s))) - 64'd1;
  end

  always_comb begin
    e = entry_i;
    if (mode_i == MODE_LEG32) begin
      if (size_i == PG_4M) e = e | (VA_W'(entry_i[20:13]) << 32);
      e = e & a20_mask(a20_en_i);
    end
    lm = low_mask[size_i];
    if (flat_i) pa_o = va_i & a20_mask(a20_en_i);
    else        pa_o = (e & PA_FIELD & ~lm) | (va_i & lm);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int unsigned PA_W = 52
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [63:0]      req_va_i,
  input  logic             cfg_paging_i,
  input  logic             cfg_pae_i,
  input  logic             cfg_long_i,
  input  logic             cfg_pse_i,
  input  logic             cfg_a20_en_i,
  input  logic [63:0]      cfg_root_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [63:0]      mem_req_addr_o,
  output logic             mem_req_wide_o,
  input  logic             mem_rsp_valid_i,
  input  logic [63:0]      mem_rsp_data_i,
  output logic             res_valid_o,
  output logic             res_fault_o,
  output logic [63:0]      res_pa_o,
  output logic [1:0]       res_size_o
);
  localparam logic [VA_W-1:0] FRAME_MASK = ((64'd1 << PA_W) - 64'd1) & ~64'hFFF;
  localparam int unsigned     CANON_LSB  = PG_SHIFT + IDX_W*N_LVL - 1;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} st_e;

  st_e             st_q;
  walk_mode_e      mode_q, mode_d, cur_mode;
  walk_lvl_e       lvl_q, start_lvl;
  logic [VA_W-1:0] va_q, base_q, root_base, cur_va;
  logic            a20_q, pse_q, cur_a20, idle;
  logic [VA_W-1:0] pa_q;
  logic            fault_q;
  pg_size_e        size_q;
  logic            canon_ok;

  logic            ent_present, ent_leaf;
  pg_size_e        ent_size, fmt_size;
  logic [VA_W-1:0] ent_next, ent_raw, fmt_pa;

  assign idle = (st_q == ST_IDLE);

  always_comb begin
    if (!cfg_paging_i)   mode_d = MODE_FLAT;
    else if (!cfg_pae_i) mode_d = MODE_LEG32;
    else if (cfg_long_i) mode_d = MODE_LONG4;
    else                 mode_d = MODE_PAE3;
  end

  always_comb begin
    case (mode_d)
      MODE_LEG32: begin root_base = cfg_root_i & ~64'hFFF; start_lvl = LVL_PD;   end
      MODE_PAE3:  begin root_base = cfg_root_i & ~64'h1F;  start_lvl = LVL_PDPT; end
      MODE_LONG4: begin root_base = cfg_root_i & FRAME_MASK; start_lvl = LVL_PML4; end
      default:    begin root_base = '0;                     start_lvl = LVL_PT;   end
    endcase
  end

  assign canon_ok = (&req_va_i[VA_W-1:CANON_LSB]) | ~(|req_va_i[VA_W-1:CANON_LSB]);

  assign cur_mode = idle ? mode_d       : mode_q;
  assign cur_va   = idle ? req_va_i     : va_q;
  assign cur_a20  = idle ? cfg_a20_en_i : a20_q;
  assign fmt_size = idle ? PG_4K        : ent_size;

  ptw_addr_gen u_addr (
    .mode_i   (mode_q),
    .lvl_i    (lvl_q),
    .va_i     (va_q),
    .base_i   (base_q),
    .a20_en_i (a20_q),
    .addr_o   (mem_req_addr_o),
    .wide_o   (mem_req_wide_o)
  );

  ptw_entry_dec #(.PA_W(PA_W)) u_dec (
    .mode_i      (mode_q),
    .lvl_i       (lvl_q),
    .data_i      (mem_rsp_data_i),
    .pse_en_i    (pse_q),
    .present_o   (ent_present),
    .leaf_o      (ent_leaf),
    .size_o      (ent_size),
    .next_base_o (ent_next),
    .entry_o     (ent_raw)
  );

  ptw_result_fmt #(.PA_W(PA_W)) u_fmt (
    .flat_i   (idle),
    .mode_i   (cur_mode),
    .size_i   (fmt_size),
    .entry_i  (ent_raw),
    .va_i     (cur_va),
    .a20_en_i (cur_a20),
    .pa_o     (fmt_pa)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      mode_q  <= MODE_FLAT;
      lvl_q   <= LVL_PT;
      va_q    <= '0;
      base_q  <= '0;
      a20_q   <= 1'b1;
      pse_q   <= 1'b0;
      pa_q    <= '0;
      fault_q <= 1'b0;
      size_q  <= PG_4K;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          mode_q  <= mode_d;
          va_q    <= req_va_i;
          a20_q   <= cfg_a20_en_i;
          pse_q   <= cfg_pse_i;
          base_q  <= root_base;
          lvl_q   <= start_lvl;
          fault_q <= 1'b0;
          size_q  <= PG_4K;
          pa_q    <= '0;
          if (mode_d == MODE_FLAT) begin
            pa_q <= fmt_pa;
            st_q <= ST_DONE;
          end else if (mode_d == MODE_LONG4 && !canon_ok) begin
            fault_q <= 1'b1;
            st_q    <= ST_DONE;
          end else begin
            st_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (mem_req_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (!ent_present) begin
            fault_q <= 1'b1;
            pa_q    <= '0;
            st_q    <= ST_DONE;
          end else if (ent_leaf) begin
            pa_q   <= fmt_pa;
            size_q <= ent_size;
            st_q   <= ST_DONE;
          end else begin
            base_q <= ent_next;
            lvl_q  <= walk_lvl_e'(lvl_q - 2'd1);
            st_q   <= ST_ISSUE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = idle;
  assign mem_req_valid_o = (st_q == ST_ISSUE);
  assign res_valid_o     = (st_q == ST_DONE);
  assign res_fault_o     = fault_q;
  assign res_pa_o        = pa_q;
  assign res_size_o      = size_q;
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        cfg_a20_en_i,
  input logic        mem_req_valid_o,
  input logic        mem_req_ready_i,
  input logic [63:0] mem_req_addr_o,
  input logic        mem_req_wide_o,
  input logic        mem_rsp_valid_i,
  input logic        res_valid_o,
  input logic        res_fault_o,
  input logic [63:0] res_pa_o,
  input logic [1:0]  res_size_o
);
  logic outst_q, a20_lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst_q   <= 1'b0;
      a20_lat_q <= 1'b1;
    end else begin
      if (mem_req_valid_o && mem_req_ready_i) outst_q <= 1'b1;
      else if (mem_rsp_valid_i)               outst_q <= 1'b0;
      if (req_valid_i && req_ready_o) a20_lat_q <= cfg_a20_en_i;
    end
  end

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_wide_o)));

  assert_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst_q |-> !mem_req_valid_o);

  assert_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o || mem_req_valid_o || outst_q) |-> !req_ready_o);

  assert_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  assert_fault_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_fault_o) |-> (res_pa_o == 64'd0 && res_size_o == 2'd0));

  assert_a20_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !a20_lat_q) |-> !mem_req_addr_o[20]);

  assert_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_wide_o) |-> (mem_req_addr_o[1:0] == 2'b00));

  assert_align_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_wide_o) |-> (mem_req_addr_o[2:0] == 3'b000));
endmodule

bind pt_walker ptw_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .cfg_a20_en_i    (cfg_a20_en_i),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_req_wide_o  (mem_req_wide_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .res_valid_o     (res_valid_o),
  .res_fault_o     (res_fault_o),
  .res_pa_o        (res_pa_o),
  .res_size_o      (res_size_o)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic        paging = 1'b0, pae = 1'b0, lng = 1'b0, pse = 1'b0, a20 = 1'b1;
  logic [63:0] root = '0;
  logic        mreq_valid, mreq_wide;
  logic        mreq_ready = 1'b0;
  logic [63:0] mreq_addr;
  logic        mrsp_valid = 1'b0;
  logic [63:0] mrsp_data = '0;
  logic        res_valid, res_fault;
  logic [63:0] res_pa;
  logic [1:0]  res_size;

  always #4 clk = ~clk;

  pt_walker u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .cfg_paging_i(paging), .cfg_pae_i(pae), .cfg_long_i(lng), .cfg_pse_i(pse),
    .cfg_a20_en_i(a20), .cfg_root_i(root),
    .mem_req_valid_o(mreq_valid), .mem_req_ready_i(mreq_ready),
    .mem_req_addr_o(mreq_addr), .mem_req_wide_o(mreq_wide),
    .mem_rsp_valid_i(mrsp_valid), .mem_rsp_data_i(mrsp_data),
    .res_valid_o(res_valid), .res_fault_o(res_fault),
    .res_pa_o(res_pa), .res_size_o(res_size)
  );

  int total = 0, bad = 0;
  int reads = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%016h expected=0x%016h", tag, what, act, exp);
    end
  endtask

  // memory model: entries keyed by exact byte address
  logic [63:0] mem [logic [63:0]];
  int          wait_cnt = 0;
  bit          stall_tog = 1'b0, stalled = 1'b0;
  logic [63:0] lat_addr;
  logic        lat_wide;

  function automatic logic [63:0] lookup(input logic [63:0] a, input logic w);
    logic [63:0] v;
    v = mem.exists(a) ? mem[a] : 64'd0;
    return w ? v : {32'hDEAD_BEEF, v[31:0]};
  endfunction

  always @(negedge clk) begin
    mrsp_valid = 1'b0;
    mreq_ready = 1'b0;
    if (!rst_n) begin
      wait_cnt = 0;
    end else if (wait_cnt > 0) begin
      wait_cnt--;
      if (wait_cnt == 0) begin
        mrsp_valid = 1'b1;
        mrsp_data  = lookup(lat_addr, lat_wide);
      end
    end else if (mreq_valid) begin
      if (stall_tog && !stalled) begin
        stalled = 1'b1;
      end else begin
        mreq_ready = 1'b1;
        lat_addr   = mreq_addr;
        lat_wide   = mreq_wide;
        wait_cnt   = 2;
        reads++;
        stalled    = 1'b0;
        stall_tog  = !stall_tog;
      end
    end
  end

  typedef struct {
    logic        fault;
    logic [63:0] pa;
    logic [1:0]  size;
    int          nreads;
    int          base;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  // monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11", "unexpected result", res_pa, 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(res_fault == e.fault, e.tag, "fault", 64'(res_fault), 64'(e.fault));
        chk(res_pa == e.pa, e.tag, "pa", res_pa, e.pa);
        chk(res_size == e.size, e.tag, "size", 64'(res_size), 64'(e.size));
        chk((reads - e.base) == e.nreads, e.tag, "reads", 64'(reads - e.base), 64'(e.nreads));
      end
    end
  end

  // driver
  task automatic xlate(input logic [63:0] va, input logic pg, input logic pa_e,
                       input logic lm, input logic ps, input logic a20e,
                       input logic [63:0] rt, input logic ef, input logic [63:0] epa,
                       input logic [1:0] esz, input int nrd, input bit poke,
                       input string tag);
    exp_t e;
    while (!req_ready) @(negedge clk);
    paging = pg; pae = pa_e; lng = lm; pse = ps; a20 = a20e; root = rt;
    req_va = va; req_valid = 1'b1;
    e.fault = ef; e.pa = epa; e.size = esz; e.nreads = nrd; e.base = reads; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    chk(req_ready == 1'b0, "R11", "ready while busy", 64'(req_ready), 64'd0);
    if (poke) begin
      req_va = 64'h0000_0000_0BAD_0000;
      @(negedge clk);
      chk(req_ready == 1'b0, "R11", "ready during poke", 64'(req_ready), 64'd0);
    end
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // legacy 32-bit tables
    mem[64'h10004]  = 64'h0002_0003;
    mem[64'h2000C]  = 64'h0055_5001;
    mem[64'h10008]  = 64'h0040_A081;
    mem[64'h40A004] = 64'h0077_7001;
    // PAE tables
    mem[64'h30030] = 64'h4_0001 - 64'h30000 + 64'h30000;
    mem[64'h40008] = 64'h5_0001;
    mem[64'h50018] = 64'h1_2345_6001;
    mem[64'h30038] = 64'h6_0001;
    mem[64'h60010] = 64'h8060_0081;
    // long-mode tables
    mem[64'h1007F8] = 64'h11_0003;
    mem[64'h110008] = 64'h12_0001;
    mem[64'h120010] = 64'h13_0001;
    mem[64'h130018] = 64'h800F_FFFF_FFFF_F001;
    mem[64'h100FF8] = 64'h14_0001;
    mem[64'h140028] = 64'h00C0_0000_0081;
    mem[64'h120020] = 64'h0A00_0081;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "reset ready", 64'(req_ready), 64'd1);
    chk(res_valid == 1'b0, "R11", "reset res_valid", 64'(res_valid), 64'd0);
    chk(mreq_valid == 1'b0, "R11", "reset mem_req_valid", 64'(mreq_valid), 64'd0);

    // R1 flat, gate open and closed
    xlate(64'h0000_0000_0012_3456, 0,0,0,0,1, 64'h0, 0, 64'h0012_3456, 2'd0, 0, 0, "R1");
    xlate(64'h0000_0000_0017_8ABC, 0,0,0,0,0, 64'h0, 0, 64'h0007_8ABC, 2'd0, 0, 0, "R1");
    // R2 legacy 4K walk, with a refused request while busy (R11)
    xlate(64'h0040_3123, 1,0,0,0,1, 64'h1_0000, 0, 64'h0055_5123, 2'd0, 2, 1, "R2");
    // R3 4 MB page, and same entry as pointer with large pages off
    xlate(64'h0080_1234, 1,0,0,1,1, 64'h1_0000, 0, 64'h5_0040_1234, 2'd2, 1, 0, "R3");
    xlate(64'h0080_1234, 1,0,0,0,1, 64'h1_0000, 0, 64'h0077_7234, 2'd0, 2, 0, "R3");
    // R8 absent directory entry
    xlate(64'h00C0_0000, 1,0,0,0,1, 64'h1_0000, 1, 64'h0, 2'd0, 1, 0, "R8");
    // R9 gate closed: root bit 20 and frame bit 20 dropped
    xlate(64'h0040_3123, 1,0,0,0,0, 64'h11_0000, 0, 64'h0045_5123, 2'd0, 2, 0, "R9");
    // R4 PAE 4K, R6 PAE 2M, R8 absent leaf
    xlate(64'h8020_3456, 1,1,0,0,1, 64'h3_0020, 0, 64'h1_2345_6456, 2'd0, 3, 1, "R4");
    xlate(64'hC040_0789, 1,1,0,0,1, 64'h3_0020, 0, 64'h8060_0789, 2'd1, 2, 0, "R6");
    xlate(64'h8020_4456, 1,1,0,0,1, 64'h3_0020, 1, 64'h0, 2'd0, 3, 0, "R8");
    // R5 / R10 long 4K with flag bit 63 stripped
    xlate(64'h0000_7F80_4040_3ABC, 1,1,1,0,1, 64'h10_0000, 0, 64'h000F_FFFF_FFFF_FABC, 2'd0, 4, 1, "R10");
    // R6 long 1G (upper-half canonical) and 2M
    xlate(64'hFFFF_FF81_5234_5678, 1,1,1,0,1, 64'h10_0000, 0, 64'h00C0_1234_5678, 2'd3, 2, 0, "R6");
    xlate(64'h0000_7F80_4081_2345, 1,1,1,0,1, 64'h10_0000, 0, 64'h0A01_2345, 2'd1, 3, 0, "R5");
    // R7 non-canonical
    xlate(64'h0000_8000_0000_0000, 1,1,1,0,1, 64'h10_0000, 1, 64'h0, 2'd0, 0, 0, "R7");
    // R8 absent at level 3 in long mode
    xlate(64'h0000_7F81_C000_0000, 1,1,1,0,1, 64'h10_0000, 1, 64'h0, 2'd0, 2, 0, "R8");

    repeat (4) @(negedge clk);
    chk(res_valid == 1'b0, "R11", "no stray result", 64'(res_valid), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule